// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns a 12-bit vector of already-synchronized GPIO input levels into per-pin interrupt conditions and a single request line. Each pin picks one of four trigger behaviours from three configuration bits: a single edge (rising or falling), both edges, or a level (high-active or low-active). Edge events are caught and held until software acknowledges them. Level conditions track the pin directly and cannot be held or acknowledged.

Software reaches the block through a plain register bus. The bus has a write strobe, a byte offset, write data, and a combinational read data path. Writes take effect on the clock edge where the strobe is high. There is no data stream at the block's edge, so no valid/ready handshake is used. The raw condition of each pin is visible whether or not that pin is enabled. A separate enable mask decides which conditions reach the masked status view and the request line.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, the sense (0x8004), both-edges (0x8008), event (0x800C), enable (0x8010), raw status (0x8014) and masked status (0x8018) registers all read 0, and `irq` is 0.
- R2: Each configuration register at 0x8004, 0x8008, 0x800C and 0x8010 holds bits [11:0] of the written word and reads them back, with bits [31:12] reading 0.
- R3: A pin in falling-edge mode (sense 0, both 0, event 0) sets its raw status bit (bit i for pin i) on the clock edge where the pin goes from 1 to 0. It reads as set from the next cycle, and a 0-to-1 change sets nothing.
- R4: A pin in rising-edge mode (sense 0, both 0, event 1) sets its raw bit on a 0-to-1 change only.
- R5: A pin in both-edge mode (sense 0, both 1) sets its raw bit on either change, whatever its event bit.
- R6: In level mode (sense 1), the raw bit equals the pin when the event bit is 1 and the inverted pin when it is 0. It changes in the same cycle as the pin and is not held.
- R7: A held edge bit stays set until a write to 0x801C with a 1 in that bit position. 0 bits in that write leave other bits alone. If a new edge arrives in the same cycle as its clear, the bit stays set. 0x801C reads 0.
- R8: Raw status at 0x8014 ignores the enable mask, and masked status at 0x8018 reads raw AND enable. Writes to either offset change nothing.
- R9: `irq` is 1 exactly when some bit is set in both raw status and the enable mask, in the same cycle.
- R10: A clear write to a pin in level mode does not change its raw bit.
- R11: Putting a pin into level mode discards its held edge bit, so it reads 0 after the pin returns to edge mode if no new edge arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 12 | Synchronized pin levels |
| irq | output | 1 | Combined enabled interrupt request |

## Verification
A held edge bit that is lost, stuck, or set by the wrong transition shows up in the raw status read one cycle after the stimulus edge. The same cycle shows whether `irq` goes high for an enabled pin. Configuration bits that are corrupted appear at once in a read-back, or as a level-mode raw bit that disagrees with the pin in the cycle it is driven. A clear that reaches the wrong bit, or loses to a simultaneous edge, is visible in the raw read right after the clear write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned PIN_CNT  = 12;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CFG_CNT  = 4;   // sense, both, event, enable

  localparam logic [ADDR_W-1:0] OFS_CFG0  = 16'h8004;  // first config register
  localparam logic [ADDR_W-1:0] OFS_RAW   = 16'h8014;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 16'h8018;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 16'h801C;

  typedef enum logic [1:0] {
    CFG_SENSE = 2'd0,
    CFG_BOTH  = 2'd1,
    CFG_EVENT = 2'd2,
    CFG_EN    = 2'd3
  } cfg_idx_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = PIN_CNT,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [NPIN-1:0] raw_stat,
  output logic [NPIN-1:0] cfg_sense,
  output logic [NPIN-1:0] cfg_both,
  output logic [NPIN-1:0] cfg_event,
  output logic [NPIN-1:0] cfg_en,
  output logic [NPIN-1:0] clr_pulse,
  output logic [DW-1:0]   bus_rdata
);
  localparam int unsigned PAD = DW - NPIN;

  logic [CFG_CNT-1:0][NPIN-1:0] cfg_q;
  logic [CFG_CNT-1:0]           cfg_hit;

  for (genvar k = 0; k < CFG_CNT; k++) begin : g_cfg
    localparam logic [AW-1:0] OFS = OFS_CFG0 + AW'(4 * k);
    assign cfg_hit[k] = (bus_addr == OFS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cfg_q[k] <= '0;
      else if (bus_wr && cfg_hit[k]) cfg_q[k] <= bus_wdata[NPIN-1:0];
    end

    // R2: a write lands in its register
    a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && cfg_hit[k]) |=> (cfg_q[k] == $past(bus_wdata[NPIN-1:0])));
  end

  assign cfg_sense = cfg_q[CFG_SENSE];
  assign cfg_both  = cfg_q[CFG_BOTH];
  assign cfg_event = cfg_q[CFG_EVENT];
  assign cfg_en    = cfg_q[CFG_EN];

  assign clr_pulse = (bus_wr && bus_addr == OFS_CLR) ? bus_wdata[NPIN-1:0] : '0;

  logic [NPIN-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < CFG_CNT; k++)
      if (cfg_hit[k]) rd_sel = cfg_q[k];
    if (bus_addr == OFS_RAW)   rd_sel = raw_stat;
    if (bus_addr == OFS_MSTAT) rd_sel = raw_stat & cfg_en;
  end
  assign bus_rdata = {{PAD{1'b0}}, rd_sel};

  // R8: status offsets are read-only
  a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_RAW || bus_addr == OFS_MSTAT)) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = PIN_CNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] cfg_sense,
  input  logic [NPIN-1:0] cfg_both,
  input  logic [NPIN-1:0] cfg_event,
  input  logic [NPIN-1:0] clr_pulse,
  output logic [NPIN-1:0] raw_stat
);
  logic [NPIN-1:0] pin_prev;
  logic [NPIN-1:0] edge_q;
  logic [NPIN-1:0] edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= '0;
    else        pin_prev <= pin_in;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall;
    assign rise = pin_in[i] & ~pin_prev[i];
    assign fall = ~pin_in[i] & pin_prev[i];
    assign edge_hit[i] = cfg_both[i] ? (rise | fall)
                                     : (cfg_event[i] ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            edge_q[i] <= 1'b0;
      else if (cfg_sense[i]) edge_q[i] <= 1'b0;
      else                   edge_q[i] <= edge_hit[i] | (edge_q[i] & ~clr_pulse[i]);
    end

    assign raw_stat[i] = cfg_sense[i] ? ~(pin_in[i] ^ cfg_event[i]) : edge_q[i];

    // R7: held edge survives when not cleared
    a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sense[i] && edge_q[i] && !clr_pulse[i]) |=> edge_q[i]);
    // R7: clear without a new edge drops the bit
    a_r7_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sense[i] && clr_pulse[i] && !edge_hit[i]) |=> !edge_q[i]);
    // R11: level mode discards the held edge
    a_r11_level_discard: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sense[i] |=> !edge_q[i]);
    // R3: a newly held edge needs a pin change
    a_r3_edge_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_q[i]) |-> ($past(pin_in[i]) != $past(pin_prev[i])));
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = PIN_CNT,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic            irq
);
  logic [NPIN-1:0] cfg_sense, cfg_both, cfg_event, cfg_en, clr_pulse, raw_stat;

  gpio_irq_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_stat  (raw_stat),
    .cfg_sense (cfg_sense),
    .cfg_both  (cfg_both),
    .cfg_event (cfg_event),
    .cfg_en    (cfg_en),
    .clr_pulse (clr_pulse),
    .bus_rdata (bus_rdata)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .cfg_sense (cfg_sense),
    .cfg_both  (cfg_both),
    .cfg_event (cfg_event),
    .clr_pulse (clr_pulse),
    .raw_stat  (raw_stat)
  );

  assign irq = |(raw_stat & cfg_en);

  // R9: a request needs some enabled pin
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_en != '0));
endmodule

// File: tb/gpio_irq_top_tb.sv
module gpio_irq_top_tb;
  localparam int PERIOD = 10;
  localparam logic [15:0] A_SENSE = 16'h8004, A_BOTH = 16'h8008, A_EVT = 16'h800C,
                          A_EN = 16'h8010, A_RAW = 16'h8014, A_MST = 16'h8018,
                          A_CLR = 16'h801C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_irq_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic drive(input logic [11:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd("R1 sense", A_SENSE, 0); rd("R1 both", A_BOTH, 0); rd("R1 event", A_EVT, 0);
    rd("R1 enable", A_EN, 0); rd("R1 raw", A_RAW, 0); rd("R1 mstat", A_MST, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs;
    wr(A_EN, 32'hFFFF_FFFF);  rd("R2 enable width", A_EN, 32'h0000_0FFF);
    wr(A_SENSE, 32'h0000_0A5A); rd("R2 sense", A_SENSE, 32'h0000_0A5A);
    wr(A_BOTH, 32'h0000_05A5);  rd("R2 both", A_BOTH, 32'h0000_05A5);
    wr(A_EVT, 32'h0000_0C33);   rd("R2 event", A_EVT, 32'h0000_0C33);
    wr(A_RAW, 32'h0000_0FFF);   rd("R8 raw write enable kept", A_EN, 32'h0000_0FFF);
    wr(A_MST, 32'h0000_0000);   rd("R8 mstat write sense kept", A_SENSE, 32'h0000_0A5A);
    rd("R7 clear reads zero", A_CLR, 0);
    wr(A_SENSE, 0); wr(A_BOTH, 0); wr(A_EVT, 0); wr(A_EN, 0);
  endtask

  task automatic t_fall;
    drive(12'h001); rd("R3 rise ignored", A_RAW, 0);
    drive(12'h000); rd("R3 fall held", A_RAW, 32'h001);
    wr(A_CLR, 32'h001); rd("R7 cleared", A_RAW, 0);
  endtask

  task automatic t_rise;
    wr(A_EVT, 32'h002);
    drive(12'h002); rd("R4 rise held", A_RAW, 32'h002);
    wr(A_CLR, 32'h002);
    drive(12'h000); rd("R4 fall ignored", A_RAW, 0);
    wr(A_EVT, 0);
  endtask

  task automatic t_both;
    wr(A_BOTH, 32'h004); wr(A_EVT, 32'h004);
    drive(12'h004); rd("R5 rise", A_RAW, 32'h004);
    wr(A_CLR, 32'h004); rd("R5 cleared", A_RAW, 0);
    drive(12'h000); rd("R5 fall", A_RAW, 32'h004);
    wr(A_CLR, 32'h004); wr(A_BOTH, 0); wr(A_EVT, 0);
  endtask

  task automatic t_level;
    wr(A_EVT, 32'h008); wr(A_SENSE, 32'h008);
    rd("R6 high-active idle", A_RAW, 0);
    @(negedge clk); pin_in = 12'h008; rd("R6 high same cycle", A_RAW, 32'h008);
    @(negedge clk); pin_in = 12'h000; rd("R6 not held", A_RAW, 0);
    wr(A_EVT, 0); rd("R6 low-active", A_RAW, 32'h008);
    wr(A_CLR, 32'h008); rd("R10 clear no effect", A_RAW, 32'h008);
    wr(A_SENSE, 0);
    rd("R11 back to edge", A_RAW, 0);
  endtask

  task automatic t_clear;
    drive(12'h011); drive(12'h000);
    rd("R3 two pins held", A_RAW, 32'h011);
    wr(A_CLR, 32'h010); rd("R7 partial clear", A_RAW, 32'h001);
    drive(12'h001);
    @(negedge clk);
    pin_in = 12'h000; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h001;
    @(negedge clk);
    bus_wr = 1'b0;
    rd("R7 edge beats clear", A_RAW, 32'h001);
  endtask

  task automatic t_mask;
    chk("R9 irq off when disabled", 32'(irq), 0);
    rd("R8 raw ignores enable", A_RAW, 32'h001);
    rd("R8 mstat zero", A_MST, 0);
    wr(A_EN, 32'h001);
    chk("R9 irq on", 32'(irq), 1);
    rd("R8 mstat", A_MST, 32'h001);
    wr(A_EN, 32'hFFE);
    chk("R9 irq other pins", 32'(irq), 0);
    wr(A_EN, 0);
  endtask

  task automatic t_switch;
    wr(A_EVT, 32'h001);
    wr(A_SENSE, 32'h001); rd("R6 level high pin low", A_RAW, 0);
    wr(A_SENSE, 0); wr(A_EVT, 0);
    rd("R11 held edge discarded", A_RAW, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_fall;
    t_rise;
    t_both;
    t_level;
    t_clear;
    t_mask;
    t_switch;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule